// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between an internal request bus and an external asynchronous static RAM of 65,536 words by 16 bits. A requester offers one request at a time through a valid/ready handshake. Each request is a single word or single byte read or write, with a 16-bit address, 16-bit write data and a 2-bit lane mask. The sequencer then drives the RAM's active-low chip select, write strobe, output enable and two lane selects. It also drives the address and the outgoing half of the data bus with a separate drive enable, and it samples the incoming half of the data bus.

The RAM has no clock, so each access is built from a whole number of controller clock cycles. Parameters set those counts: read access length, data setup before the write strobe, write strobe width, and the extra idle gap placed before a write that follows a read. With a 10 ns clock and the slower speed grade, the defaults are a 2-cycle read, 1 setup cycle, a 1-cycle strobe and 1 turnaround cycle. Read data is registered at the end of the read and announced with a one-cycle valid pulse.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `mem_cs_n`, `mem_oe_n`, `mem_we_n`, `mem_lb_n` and `mem_ub_n` are all 1, `mem_dq_oe` is 0, `req_ready` is 1 and `rd_valid` is 0.
- R2: `req_ready` is 1 only when no access is in progress. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. While an access is in progress `req_ready` stays 0 and no request is taken. While idle, all strobes are 1 and the data bus is not driven.
- R3: A read taken at edge k holds `mem_cs_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for exactly RD_CYC cycles, starting in the cycle after edge k. It then returns to idle.
- R4: At the edge that ends the last read cycle, `rd_data` captures `mem_dq_in` and `rd_valid` is 1 for the following cycle only. Bytes of a lane not enabled in the mask read as 0. `rd_data` holds its value until the next capture.
- R5: Mask bit 0 enables the low lane (data bits 7:0), which drives `mem_lb_n`. Mask bit 1 enables the high lane (bits 15:8), which drives `mem_ub_n`. A lane select is 0 only while chip select is 0 and its mask bit is 1.
- R6: A write taken at edge k holds chip select 0, `mem_we_n`=1 and `mem_dq_oe`=1 for SETUP_CYC cycles. It then holds `mem_we_n`=0 for PULSE_CYC cycles. After that, strobes and bus drive are released together in the same cycle.
- R7: `mem_oe_n` is 1 for the whole of a write. `mem_dq_oe` is 1 only in write cycles, and never while `mem_oe_n` is 0.
- R8: A write taken when the previous access was a read first spends TURN_CYC cycles with all strobes 1 and the bus released. Other orderings (write after write, read after anything) add no such cycles.
- R9: A request with mask 00 still runs its full sequence with both lane selects 1. A read with mask 00 returns `rd_data`=0, and a write with mask 00 leaves the RAM contents unchanged.
- R10: `mem_addr` equals the accepted address in every active cycle of an access. `mem_dq_out` equals the accepted write data in every cycle where the bus is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane enables: bit 0 low byte, bit 1 high byte |
| rd_valid | output | 1 | One-cycle pulse: rd_data updated |
| rd_data | output | 16 | Captured read data, disabled lanes zero |
| mem_addr | output | 16 | RAM address |
| mem_dq_out | output | 16 | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data returned by the RAM |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Low lane select, active low |
| mem_ub_n | output | 1 | High lane select, active low |

## Verification
The bound checker checks, on every cycle, the rules that never depend on history length. These are: output enable and write strobe are never low together; the bus is driven only while selected with output enable high; lane selects stay high without chip select; the write strobe falls only after data was driven the cycle before; the address is steady across an access; a read-valid pulse follows a cycle with output enable low. The exact phase lengths set by the parameters, the conditional turnaround before a write that follows a read, lane zeroing in captured data, and the fact that a masked write leaves RAM contents untouched can only be shown by the bench's scenarios. In those scenarios, a cycle-indexed expectation table and a model RAM driven by the pins are compared against the outputs.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

   // byte lanes carried by the external data bus
   localparam int LANE_W = 8;
   localparam int LANES  = 2;

   // sequencer phases
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_TURN  = 3'd1,
      ST_SETUP = 3'd2,
      ST_PULSE = 3'd3,
      ST_READ  = 3'd4
   } seq_state_e;

   // largest of four cycle counts
   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

   // counter width able to hold count-1 for every phase
   function automatic int cnt_bits(input int maxc);
      if (maxc <= 2) return 1;
      return $clog2(maxc);
   endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);

   logic [CNT_W-1:0] remain;

   always_ff @(posedge clk) begin
      if (rst) begin
         remain <= '0;
      end else if (load) begin
         remain <= load_val;
      end else if (remain != '0) begin
         remain <= remain - 1'b1;
      end
   end

   // the current phase ends at the edge that closes a cycle with zero remaining
   assign done = (remain == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
   import sram_seq_pkg::*;
#(
   parameter int RD_CYC    = 2,
   parameter int SETUP_CYC = 1,
   parameter int PULSE_CYC = 1,
   parameter int TURN_CYC  = 1,
   parameter int CNT_W     = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic             phase_done,
   output seq_state_e       state,
   output logic             accept,
   output logic             capture,
   output logic             tm_load,
   output logic [CNT_W-1:0] tm_val
);

   localparam logic [CNT_W-1:0] RD_LD    = CNT_W'(RD_CYC - 1);
   localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
   localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYC - 1);
   localparam logic [CNT_W-1:0] TURN_LD  = CNT_W'((TURN_CYC > 0) ? TURN_CYC - 1 : 0);

   seq_state_e nxt;
   logic       need_turn;

   assign accept = (state == ST_IDLE) && req_valid;

   // history of the last access, present only when a turnaround gap is wanted
   generate
      if (TURN_CYC > 0) begin : g_turn
         logic last_rd;
         always_ff @(posedge clk) begin
            if (rst) begin
               last_rd <= 1'b0;
            end else if (capture) begin
               last_rd <= 1'b1;
            end else if (accept && req_write) begin
               last_rd <= 1'b0;
            end
         end
         assign need_turn = last_rd;
      end else begin : g_no_turn
         assign need_turn = 1'b0;
      end
   endgenerate

   always_comb begin
      nxt     = state;
      capture = 1'b0;
      tm_load = 1'b0;
      tm_val  = '0;
      unique case (state)
         ST_IDLE: begin
            if (req_valid) begin
               tm_load = 1'b1;
               if (!req_write) begin
                  nxt    = ST_READ;
                  tm_val = RD_LD;
               end else if (need_turn) begin
                  nxt    = ST_TURN;
                  tm_val = TURN_LD;
               end else begin
                  nxt    = ST_SETUP;
                  tm_val = SETUP_LD;
               end
            end
         end
         ST_TURN: begin
            if (phase_done) begin
               nxt     = ST_SETUP;
               tm_load = 1'b1;
               tm_val  = SETUP_LD;
            end
         end
         ST_SETUP: begin
            if (phase_done) begin
               nxt     = ST_PULSE;
               tm_load = 1'b1;
               tm_val  = PULSE_LD;
            end
         end
         ST_PULSE: begin
            if (phase_done) begin
               nxt = ST_IDLE;
            end
         end
         ST_READ: begin
            if (phase_done) begin
               nxt     = ST_IDLE;
               capture = 1'b1;
            end
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_IDLE;
      end else begin
         state <= nxt;
      end
   end

endmodule

// File: rtl/sram_seq_lanes.sv
module sram_seq_lanes
   import sram_seq_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  seq_state_e        state,
   input  logic              accept,
   input  logic              capture,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LANES-1:0]  req_mask,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   output logic              mem_cs_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [LANES-1:0]  lane_n,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);

   logic [ADDR_W-1:0] hold_addr;
   logic [DATA_W-1:0] hold_data;
   logic [LANES-1:0]  hold_mask;
   logic              selected;

   // request fields are frozen for the whole access
   always_ff @(posedge clk) begin
      if (rst) begin
         hold_addr <= '0;
         hold_data <= '0;
         hold_mask <= '0;
      end else if (accept) begin
         hold_addr <= req_addr;
         hold_data <= req_wdata;
         hold_mask <= req_mask;
      end
   end

   // strobe decode from the phase register
   assign selected   = (state == ST_READ) || (state == ST_SETUP) || (state == ST_PULSE);
   assign mem_cs_n   = !selected;
   assign mem_oe_n   = (state != ST_READ);
   assign mem_we_n   = (state != ST_PULSE);
   assign mem_dq_oe  = (state == ST_SETUP) || (state == ST_PULSE);
   assign mem_addr   = hold_addr;
   assign mem_dq_out = hold_data;

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= capture;
      end
   end

   generate
      for (genvar li = 0; li < LANES; li++) begin : g_lane
         assign lane_n[li] = mem_cs_n || !hold_mask[li];

         always_ff @(posedge clk) begin
            if (rst) begin
               rd_data[li*LANE_W +: LANE_W] <= '0;
            end else if (capture) begin
               rd_data[li*LANE_W +: LANE_W] <= hold_mask[li] ?
                                               mem_dq_in[li*LANE_W +: LANE_W] : '0;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
   import sram_seq_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 16,
   parameter int RD_CYC    = 2,
   parameter int SETUP_CYC = 1,
   parameter int PULSE_CYC = 1,
   parameter int TURN_CYC  = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [1:0]        req_mask,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic              mem_cs_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic              mem_lb_n,
   output logic              mem_ub_n
);

   localparam int MAXC  = max4(RD_CYC, SETUP_CYC, PULSE_CYC, TURN_CYC);
   localparam int CNT_W = cnt_bits(MAXC);

   // elaboration-time parameter checks
   generate
      if (DATA_W != LANES * LANE_W) begin : g_bad_width
         $error("sram_seq_ctrl: DATA_W must equal two byte lanes");
      end
      if (RD_CYC < 1 || SETUP_CYC < 1 || PULSE_CYC < 1) begin : g_bad_cycles
         $error("sram_seq_ctrl: read, setup and pulse counts must be at least one");
      end
      if (TURN_CYC < 0) begin : g_bad_turn
         $error("sram_seq_ctrl: turnaround count must not be negative");
      end
   endgenerate

   seq_state_e       state;
   logic             accept;
   logic             capture;
   logic             tm_load;
   logic [CNT_W-1:0] tm_val;
   logic             phase_done;
   logic [LANES-1:0] lane_n;

   sram_seq_fsm #(
      .RD_CYC   (RD_CYC),
      .SETUP_CYC(SETUP_CYC),
      .PULSE_CYC(PULSE_CYC),
      .TURN_CYC (TURN_CYC),
      .CNT_W    (CNT_W)
   ) u_fsm (
      .clk       (clk),
      .rst       (rst),
      .req_valid (req_valid),
      .req_write (req_write),
      .phase_done(phase_done),
      .state     (state),
      .accept    (accept),
      .capture   (capture),
      .tm_load   (tm_load),
      .tm_val    (tm_val)
   );

   sram_seq_timer #(
      .CNT_W(CNT_W)
   ) u_timer (
      .clk     (clk),
      .rst     (rst),
      .load    (tm_load),
      .load_val(tm_val),
      .done    (phase_done)
   );

   sram_seq_lanes #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
   ) u_lanes (
      .clk       (clk),
      .rst       (rst),
      .state     (state),
      .accept    (accept),
      .capture   (capture),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .req_mask  (req_mask),
      .mem_dq_in (mem_dq_in),
      .mem_addr  (mem_addr),
      .mem_dq_out(mem_dq_out),
      .mem_dq_oe (mem_dq_oe),
      .mem_cs_n  (mem_cs_n),
      .mem_we_n  (mem_we_n),
      .mem_oe_n  (mem_oe_n),
      .lane_n    (lane_n),
      .rd_valid  (rd_valid),
      .rd_data   (rd_data)
   );

   assign req_ready = (state == ST_IDLE);
   assign mem_lb_n  = lane_n[0];
   assign mem_ub_n  = lane_n[1];

endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              req_ready,
   input logic              rd_valid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_dq_out,
   input logic              mem_dq_oe,
   input logic              mem_cs_n,
   input logic              mem_we_n,
   input logic              mem_oe_n,
   input logic              mem_lb_n,
   input logic              mem_ub_n
);

   AST_OE_WE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
      !(!mem_oe_n && !mem_we_n)); // R7

   AST_DRIVE_ONLY_WRITE: assert property (@(posedge clk) disable iff (rst)
      mem_dq_oe |-> (!mem_cs_n && mem_oe_n)); // R7

   AST_LANES_NEED_CS: assert property (@(posedge clk) disable iff (rst)
      mem_cs_n |-> (mem_lb_n && mem_ub_n)); // R5

   AST_READY_MEANS_IDLE: assert property (@(posedge clk) disable iff (rst)
      req_ready |-> (mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe)); // R2

   AST_DATA_BEFORE_STROBE: assert property (@(posedge clk) disable iff (rst)
      $fell(mem_we_n) |-> $past(mem_dq_oe)); // R6

   AST_STROBE_WITH_DATA: assert property (@(posedge clk) disable iff (rst)
      !mem_we_n |-> mem_dq_oe); // R6

   AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (rst)
      (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R10

   AST_WDATA_STEADY: assert property (@(posedge clk) disable iff (rst)
      (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out)); // R10

   AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
      rd_valid |-> $past(!mem_oe_n)); // R4

   AST_TURN_GAP: assert property (@(posedge clk) disable iff (rst)
      $rose(mem_dq_oe) |-> $past(mem_oe_n)); // R8

endmodule

bind sram_seq_ctrl sram_seq_chk #(
   .ADDR_W(ADDR_W),
   .DATA_W(DATA_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .req_ready (req_ready),
   .rd_valid  (rd_valid),
   .mem_addr  (mem_addr),
   .mem_dq_out(mem_dq_out),
   .mem_dq_oe (mem_dq_oe),
   .mem_cs_n  (mem_cs_n),
   .mem_we_n  (mem_we_n),
   .mem_oe_n  (mem_oe_n),
   .mem_lb_n  (mem_lb_n),
   .mem_ub_n  (mem_ub_n)
);

// File: tb/sram_seq_ctrl_test.sv
module sram_seq_ctrl_test;

   localparam int CLK_PERIOD = 10;
   localparam int RD_C = 2;
   localparam int SU_C = 1;
   localparam int PW_C = 1;
   localparam int TA_C = 1;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [15:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_mask = '0;
   logic        rd_valid;
   logic [15:0] rd_data;
   logic [15:0] mem_addr;
   logic [15:0] mem_dq_out;
   logic        mem_dq_oe;
   logic [15:0] mem_dq_in = 16'hA5A5;
   logic        mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n;

   sram_seq_ctrl #(
      .RD_CYC(RD_C), .SETUP_CYC(SU_C), .PULSE_CYC(PW_C), .TURN_CYC(TA_C)
   ) uut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_mask(req_mask), .rd_valid(rd_valid), .rd_data(rd_data),
      .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
      .mem_dq_in(mem_dq_in), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
      .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      logic        cs_n, oe_n, we_n, lb_n, ub_n, dq_oe;
      logic [15:0] addr, dout;
      string       tag;
   } pin_exp_t;

   pin_exp_t    exp_pin [int];
   logic [15:0] exp_rd  [int];
   string       exp_rd_tag [int];
   logic [15:0] ref_mem [int];
   logic [15:0] ram_mem [int];

   int  checks = 0;
   int  errors = 0;
   int  cyc = 0;
   bit  checking = 0;
   bit  model_last_rd = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h (cycle %0d)", tag, what, act, expv, cyc);
      end
   endtask

   always @(posedge clk) cyc <= cyc + 1;

   // watchdog
   always @(posedge clk) begin
      if (cyc > 150000) begin
         errors++;
         checks++;
         $display("FAIL R2 watchdog: actual=%0d expected=%0d", cyc, 150000);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   function automatic logic [15:0] rd_word(input logic [15:0] mem [int], input int a);
      return mem.exists(a) ? mem[a] : 16'h0000;
   endfunction

   // cycle-by-cycle comparison and model RAM, all at the falling edge
   always @(negedge clk) begin
      if (checking) begin
         if (exp_pin.exists(cyc)) begin
            pin_exp_t e;
            e = exp_pin[cyc];
            chk(req_ready == 1'b0, "R2", "ready while busy", 32'(req_ready), 32'd0);
            chk({mem_cs_n, mem_oe_n, mem_we_n} == {e.cs_n, e.oe_n, e.we_n}, e.tag,
                "cs/oe/we", 32'({mem_cs_n, mem_oe_n, mem_we_n}), 32'({e.cs_n, e.oe_n, e.we_n}));
            chk({mem_lb_n, mem_ub_n} == {e.lb_n, e.ub_n}, "R5", "lb/ub",
                32'({mem_lb_n, mem_ub_n}), 32'({e.lb_n, e.ub_n}));
            chk(mem_dq_oe == e.dq_oe, "R7", "dq_oe", 32'(mem_dq_oe), 32'(e.dq_oe));
            if (!e.cs_n)
               chk(mem_addr == e.addr, "R10", "address", 32'(mem_addr), 32'(e.addr));
            if (e.dq_oe)
               chk(mem_dq_out == e.dout, "R10", "write data", 32'(mem_dq_out), 32'(e.dout));
            exp_pin.delete(cyc);
         end else begin
            chk(req_ready == 1'b1, "R2", "ready while idle", 32'(req_ready), 32'd1);
            chk({mem_cs_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe} == 6'b111110,
                "R2", "idle pins", 32'({mem_cs_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe}),
                32'(6'b111110));
         end
         if (exp_rd.exists(cyc)) begin
            chk(rd_valid == 1'b1, "R4", "rd_valid pulse", 32'(rd_valid), 32'd1);
            chk(rd_data == exp_rd[cyc], exp_rd_tag[cyc], "rd_data", 32'(rd_data), 32'(exp_rd[cyc]));
            exp_rd.delete(cyc);
            exp_rd_tag.delete(cyc);
         end else begin
            chk(rd_valid == 1'b0, "R4", "rd_valid quiet", 32'(rd_valid), 32'd0);
         end
      end
      // model RAM: write lanes while selected with write strobe low
      if (!mem_cs_n && !mem_we_n) begin
         logic [15:0] w;
         w = rd_word(ram_mem, int'(mem_addr));
         if (!mem_lb_n && mem_dq_oe) w[7:0]  = mem_dq_out[7:0];
         if (!mem_ub_n && mem_dq_oe) w[15:8] = mem_dq_out[15:8];
         ram_mem[int'(mem_addr)] = w;
      end
      // model RAM: drive selected lanes while reading, filler elsewhere
      begin
         logic [15:0] r;
         r = 16'hA5A5;
         if (!mem_cs_n && !mem_oe_n && mem_we_n) begin
            if (!mem_lb_n) r[7:0]  = rd_word(ram_mem, int'(mem_addr)) >> 0;
            if (!mem_ub_n) r[15:8] = rd_word(ram_mem, int'(mem_addr)) >> 8;
         end
         mem_dq_in <= r;
      end
   end

   task automatic issue(input bit wr, input logic [15:0] a, input logic [15:0] d,
                        input logic [1:0] m);
      int       t;
      pin_exp_t e;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = a;
      req_wdata = d;
      req_mask  = m;
      t = cyc + 1;
      e.addr = a;
      e.dout = d;
      e.lb_n = !m[0];
      e.ub_n = !m[1];
      if (wr) begin
         if (model_last_rd) begin
            for (int i = 0; i < TA_C; i++) begin
               pin_exp_t g;
               g = e;
               {g.cs_n, g.oe_n, g.we_n, g.lb_n, g.ub_n, g.dq_oe} = 6'b111110;
               g.tag = "R8";
               exp_pin[t] = g;
               t++;
            end
         end
         for (int i = 0; i < SU_C; i++) begin
            e.cs_n = 0; e.oe_n = 1; e.we_n = 1; e.dq_oe = 1; e.tag = "R6";
            exp_pin[t] = e;
            t++;
         end
         for (int i = 0; i < PW_C; i++) begin
            e.cs_n = 0; e.oe_n = 1; e.we_n = 0; e.dq_oe = 1; e.tag = "R6";
            exp_pin[t] = e;
            t++;
         end
         begin
            logic [15:0] w;
            w = rd_word(ref_mem, int'(a));
            if (m[0]) w[7:0]  = d[7:0];
            if (m[1]) w[15:8] = d[15:8];
            ref_mem[int'(a)] = w;
         end
         model_last_rd = 0;
      end else begin
         logic [15:0] x;
         for (int i = 0; i < RD_C; i++) begin
            e.cs_n = 0; e.oe_n = 0; e.we_n = 1; e.dq_oe = 0; e.tag = "R3";
            exp_pin[t] = e;
            t++;
         end
         x = rd_word(ref_mem, int'(a));
         if (!m[0]) x[7:0]  = 8'h00;
         if (!m[1]) x[15:8] = 8'h00;
         exp_rd[t] = x;
         exp_rd_tag[t] = (m == 2'b00) ? "R9" : "R4";
         model_last_rd = 1;
      end
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      int seed;
      logic [15:0] pool [4];
      pool[0] = 16'h0000; pool[1] = 16'hFFFF; pool[2] = 16'h1234; pool[3] = 16'h8001;

      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk({mem_cs_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n} == 5'b11111, "R1", "strobes in reset",
          32'({mem_cs_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n}), 32'h1f);
      chk(mem_dq_oe == 1'b0, "R1", "bus released in reset", 32'(mem_dq_oe), 32'd0);
      chk(req_ready == 1'b1 && rd_valid == 1'b0, "R1", "ready/valid in reset",
          32'({req_ready, rd_valid}), 32'h2);
      rst = 1'b0;
      checking = 1;

      // full word write then read back
      issue(1, 16'h1234, 16'hBEEF, 2'b11);
      issue(0, 16'h1234, 16'h0000, 2'b11);
      // single-lane writes (R5)
      issue(1, 16'h1234, 16'h0011, 2'b01);
      issue(0, 16'h1234, 16'h0000, 2'b11);
      issue(1, 16'h1234, 16'hAB77, 2'b10);
      issue(0, 16'h1234, 16'h0000, 2'b11);
      // single-lane reads zero the other lane (R4)
      issue(0, 16'h1234, 16'h0000, 2'b01);
      issue(0, 16'h1234, 16'h0000, 2'b10);
      // empty mask (R9): read yields zero, write changes nothing
      issue(0, 16'h1234, 16'h0000, 2'b00);
      issue(1, 16'h1234, 16'h5555, 2'b00);
      issue(0, 16'h1234, 16'h0000, 2'b11);
      // orderings around the turnaround gap (R8)
      idle(3);
      issue(1, 16'hFFFF, 16'h0F0F, 2'b11);
      issue(1, 16'h0000, 16'hF0F0, 2'b11);
      issue(0, 16'hFFFF, 16'h0000, 2'b11);
      issue(0, 16'h0000, 16'h0000, 2'b11);
      issue(1, 16'h8001, 16'h1357, 2'b11);
      idle(2);
      issue(0, 16'h8001, 16'h0000, 2'b11);
      idle(4);
      issue(1, 16'h8001, 16'h2468, 2'b01);
      issue(0, 16'h8001, 16'h0000, 2'b11);

      // mixed traffic
      seed = 32'h1ACE;
      for (int i = 0; i < 60; i++) begin
         seed = seed * 1103515245 + 12345;
         issue(seed[20], pool[seed[17:16]], seed[15:0] ^ 16'(i), seed[23:22]);
         if (seed[27:26] == 2'b00) idle(int'(seed[29:28]));
      end
      idle(8);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule